// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block drives the four coil transistors of a two-coil stepper motor. It steps through a circular table of coil patterns. Full-step mode energises two coils at a time, which gives high torque. Half-step mode alternates between one and two energised coils, so on a four-pole motor each step moves half as far, down to 45-degree positions. Walking the table forwards turns the motor clockwise and walking it backwards turns it counterclockwise.

Steps are paced by a programmable dwell, given as a count of clock cycles. A parameter sets a floor on the dwell so that the motor is never stepped faster than it can follow. The block can run freely. It can also be given a budget of steps: it performs exactly that many, then holds the last pattern and raises `done`. Switching between full-step and half-step mode never makes the coil pattern jump. When the current entry has only one coil on, the next full-step move goes a single half-step to the neighbouring two-coil entry and then carries on in two-coil steps.

Top module: `stepper_seq`

## Requirements
- R1: After reset `coils` and `step_pulse` are 0. The position is the entry 1100 (outputs 3..0), and this pattern appears as soon as `enable` is raised.
- R2: While `enable` is low, `coils` is 0000, no step occurs and the position is kept. On re-enable the held pattern reappears and stepping continues from it.
- R3: In half-step mode (`half_mode`=1) with `dir_ccw`=0 the patterns follow the circular order 1000, 1100, 0100, 0110, 0010, 0011, 0001, 1001, wrapping from 1001 back to 1000.
- R4: In full-step mode (`half_mode`=0) with `dir_ccw`=0 the patterns follow the circular order 1100, 0110, 0011, 1001, wrapping.
- R5: With `dir_ccw`=1 either table is walked in reverse order.
- R6: Steps are spaced by exactly D clock cycles, where D = max(`dwell_cycles`, MIN_DWELL). The first step comes D cycles after `enable` rises or after a `start` pulse. `step_pulse` is high for one cycle, the cycle in which the new pattern first appears.
- R7: A `dwell_cycles` value below MIN_DWELL, including 0, gives a spacing of exactly MIN_DWELL cycles.
- R8: Changing mode never skips a pattern. In full-step mode from a single-coil entry, the next step moves one half-step in the current direction to a two-coil entry. Half-step mode continues from whatever entry is current.
- R9: With `free_run`=0, a `start` pulse loads `step_count`. `done` falls, exactly that many steps follow, and then `done` rises in the cycle of the last step. The last pattern is then held with no further steps.
- R10: A `start` with `step_count`=0 leaves `done` high and produces no step.
- R11: With `free_run`=1 the step budget is ignored and `done` is low. Stepping continues without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Energise coils and allow stepping |
| half_mode | input | 1 | 1 = half-step table, 0 = full-step |
| dir_ccw | input | 1 | 1 = counterclockwise (reverse order) |
| free_run | input | 1 | 1 = ignore the step budget |
| dwell_cycles | input | DWELL_W | Requested cycles between steps |
| start | input | 1 | Load `step_count` and restart the dwell |
| step_count | input | CNT_W | Number of steps for a budgeted run |
| coils | output | 4 | Coil drive pattern, bits 3..0 |
| step_pulse | output | 1 | One cycle high when a new pattern appears |
| done | output | 1 | Budget exhausted (only when `free_run`=0) |

## Verification
The bench builds the block with MIN_DWELL=4, DWELL_W=8 and CNT_W=6. With these values both full tables, including their wraps, can be walked in a few dozen cycles. The dwell floor can be reached from either side: a request of 5 is honoured as 5, while requests of 1 and 0 are both raised to 4. Step budgets of 0 and 3 cover the empty run and a short counted run. The mode-switch cases start from a single-coil entry in each direction.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef logic [2:0] phase_t;

  // Position after reset: the two-coil entry 1100.
  localparam phase_t HOME_PHASE = 3'd1;

  // Half-step position to coil pattern; odd positions are the two-coil entries.
  function automatic logic [3:0] coil_pattern(input phase_t p);
    logic [3:0] pat;
    case (p)
      3'd0: pat = 4'b1000;
      3'd1: pat = 4'b1100;
      3'd2: pat = 4'b0100;
      3'd3: pat = 4'b0110;
      3'd4: pat = 4'b0010;
      3'd5: pat = 4'b0011;
      3'd6: pat = 4'b0001;
      default: pat = 4'b1001;
    endcase
    return pat;
  endfunction

  // Next position. Full mode strides 2 from a two-coil entry and 1 from a single-coil one.
  function automatic phase_t advance(input phase_t p, input logic half, input logic ccw);
    phase_t stride;
    stride = (half || !p[0]) ? 3'd1 : 3'd2;
    return ccw ? phase_t'(p - stride) : phase_t'(p + stride);
  endfunction

endpackage

// File: rtl/step_dwell_timer.sv
module step_dwell_timer #(
  parameter int DWELL_W   = 24,
  parameter int MIN_DWELL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [DWELL_W-1:0] dwell_cycles,
  output logic               expired
);
  localparam logic [DWELL_W-1:0] MIN_D = DWELL_W'(MIN_DWELL);

  logic [DWELL_W-1:0] cnt;
  logic [DWELL_W-1:0] eff_dwell;
  logic [DWELL_W-1:0] reload;

  assign eff_dwell = (dwell_cycles < MIN_D) ? MIN_D : dwell_cycles;
  assign reload    = eff_dwell - DWELL_W'(1);
  assign expired   = run && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= MIN_D - DWELL_W'(1);
    else if (!run || restart || cnt == '0) cnt <= reload;
    else                                 cnt <= cnt - DWELL_W'(1);
  end
endmodule

// File: rtl/step_budget.sv
module step_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  input  logic             consume,
  output logic             empty
);
  logic [CNT_W-1:0] remaining;

  assign empty = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                remaining <= '0;
    else if (load)             remaining <= load_value;
    else if (consume && !empty) remaining <= remaining - CNT_W'(1);
  end
endmodule

// File: rtl/phase_walker.sv
module phase_walker
  import stepper_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  input  logic   half_mode,
  input  logic   dir_ccw,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= HOME_PHASE;
    else if (step_en) phase <= advance(phase, half_mode, dir_ccw);
  end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int DWELL_W   = 24,
  parameter int CNT_W     = 16,
  parameter int MIN_DWELL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               half_mode,
  input  logic               dir_ccw,
  input  logic               free_run,
  input  logic [DWELL_W-1:0] dwell_cycles,
  input  logic               start,
  input  logic [CNT_W-1:0]   step_count,
  output logic [3:0]         coils,
  output logic               step_pulse,
  output logic               done
);
  logic   dwell_expired;
  logic   budget_empty;
  logic   fire;
  phase_t phase;

  step_dwell_timer #(.DWELL_W(DWELL_W), .MIN_DWELL(MIN_DWELL)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(enable), .restart(start),
    .dwell_cycles(dwell_cycles), .expired(dwell_expired)
  );

  step_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(start), .load_value(step_count),
    .consume(fire && !free_run), .empty(budget_empty)
  );

  assign fire = dwell_expired && (free_run || !budget_empty);

  phase_walker u_walker (
    .clk(clk), .rst_n(rst_n), .step_en(fire),
    .half_mode(half_mode), .dir_ccw(dir_ccw), .phase(phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) step_pulse <= 1'b0;
    else        step_pulse <= fire;
  end

  assign coils = enable ? coil_pattern(phase) : 4'b0000;
  assign done  = !free_run && budget_empty;
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk #(
  parameter int MIN_DWELL = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [3:0] coils,
  input logic       step_pulse,
  input logic       done
);
  localparam int GW = $clog2(MIN_DWELL + 2);

  logic [GW-1:0] gap;
  logic          seen_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0;
      seen_step <= 1'b0;
    end else if (step_pulse) begin
      gap <= GW'(1);
      seen_step <= 1'b1;
    end else if (gap < GW'(MIN_DWELL)) begin
      gap <= gap + GW'(1);
    end
  end

  // R6 / R7: steps never closer than the dwell floor
  a_r7_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse && seen_step |-> gap >= GW'(MIN_DWELL));

  // R3 / R4: a step moves to a pattern one or two bits away from the previous one
  a_r3_adjacent_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse && enable && $past(enable) |->
      ($countones(coils ^ $past(coils)) inside {1, 2}) && (coils != 4'b0000));

  // R6: the pattern only changes in a step cycle while enabled
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    enable && $past(enable) && !step_pulse |-> $stable(coils));

  // R9: no step once the budget has been exhausted
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> !step_pulse);

  // R2: energised output implies enable
  a_r2_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    coils != 4'b0000 |-> enable);
endmodule

bind stepper_seq stepper_seq_chk #(.MIN_DWELL(MIN_DWELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .coils(coils),
  .step_pulse(step_pulse), .done(done)
);

// File: tb/test_stepper_seq.sv
`timescale 1ns/1ps
module test_stepper_seq;
  localparam int DW = 8;
  localparam int CW = 6;
  localparam int MIND = 4;

  logic clk = 1'b0;
  logic rst_n, enable, half_mode, dir_ccw, free_run, start;
  logic [DW-1:0] dwell_cycles;
  logic [CW-1:0] step_count;
  logic [3:0] coils;
  logic step_pulse, done;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // Independent tables written from the requirements
  logic [3:0] half_tab [8] = '{4'b1000, 4'b1100, 4'b0100, 4'b0110,
                               4'b0010, 4'b0011, 4'b0001, 4'b1001};
  logic [3:0] full_tab [4] = '{4'b1100, 4'b0110, 4'b0011, 4'b1001};

  always #2.5 clk = ~clk;

  stepper_seq #(.DWELL_W(DW), .CNT_W(CW), .MIN_DWELL(MIND)) i_stepper_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_mode(half_mode),
    .dir_ccw(dir_ccw), .free_run(free_run), .dwell_cycles(dwell_cycles),
    .start(start), .step_count(step_count), .coils(coils),
    .step_pulse(step_pulse), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_step(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!step_pulse && n < 300);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0; half_mode = 1'b1; dir_ccw = 1'b0;
    free_run = 1'b1; start = 1'b0; dwell_cycles = DW'(5); step_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    free_run = 1'b0;
    @(negedge clk);
    check(coils == 4'b0000, "R1 coils after reset", coils, 0);
    check(step_pulse == 1'b0, "R1 step_pulse after reset", step_pulse, 0);
    check(done == 1'b1, "R9 done with empty budget", done, 1);
    free_run = 1'b1;
    enable = 1'b1;
    #0.1;
    check(coils == 4'b1100, "R1 home pattern on enable", coils, 4'hc);
    wait_step(n);
    check(n == 5, "R6 first step delay", n, 5);
  endtask

  task automatic t_walk(input bit half, input bit ccw, input int dwell, input int nsteps,
                        input string req);
    int n, pos, len;
    do_reset();
    half_mode = half; dir_ccw = ccw; dwell_cycles = DW'(dwell);
    @(negedge clk);
    enable = 1'b1;
    len = half ? 8 : 4;
    pos = half ? 1 : 0;
    for (int k = 0; k < nsteps; k++) begin
      wait_step(n);
      pos = ccw ? (pos + len - 1) % len : (pos + 1) % len;
      check(coils == (half ? half_tab[pos] : full_tab[pos]), req, coils,
            half ? half_tab[pos] : full_tab[pos]);
      check(n == ((dwell < MIND) ? MIND : dwell), "R6 spacing", n,
            (dwell < MIND) ? MIND : dwell);
    end
    @(negedge clk);
    check(step_pulse == 1'b0, "R6 pulse width one cycle", step_pulse, 0);
  endtask

  task automatic t_min_dwell();
    t_walk(1'b1, 1'b0, 1, 3, "R7 half cw with dwell 1");
    t_walk(1'b0, 1'b0, 0, 3, "R7 full cw with dwell 0");
  endtask

  task automatic t_mode_switch();
    int n;
    do_reset();
    @(negedge clk);
    enable = 1'b1;
    wait_step(n);
    check(coils == 4'b0100, "R8 half step before switch", coils, 4'h4);
    half_mode = 1'b0;
    wait_step(n);
    check(coils == 4'b0110, "R8 single-coil to full cw", coils, 4'h6);
    wait_step(n);
    check(coils == 4'b0011, "R8 full stride after switch", coils, 4'h3);
    half_mode = 1'b1;
    wait_step(n);
    check(coils == 4'b0001, "R8 full to half continues", coils, 4'h1);
    half_mode = 1'b0; dir_ccw = 1'b1;
    wait_step(n);
    check(coils == 4'b0011, "R8 single-coil to full ccw", coils, 4'h3);
    wait_step(n);
    check(coils == 4'b0110, "R8 full ccw stride", coils, 4'h6);
  endtask

  task automatic t_disable_hold();
    int n;
    bit quiet;
    do_reset();
    @(negedge clk);
    enable = 1'b1;
    wait_step(n);
    wait_step(n);
    check(coils == 4'b0110, "R2 pattern before disable", coils, 4'h6);
    enable = 1'b0;
    quiet = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (coils != 4'b0000 || step_pulse) quiet = 0;
    end
    check(quiet, "R2 off and idle while disabled", quiet, 1);
    enable = 1'b1;
    #0.1;
    check(coils == 4'b0110, "R2 held pattern on re-enable", coils, 4'h6);
    wait_step(n);
    check(coils == 4'b0010, "R2 continues after re-enable", coils, 4'h2);
    check(n == 5, "R6 delay after re-enable", n, 5);
  endtask

  task automatic t_counted();
    int n;
    bit quiet;
    do_reset();
    half_mode = 1'b0; free_run = 1'b0; step_count = CW'(3);
    enable = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R9 done falls after start", done, 0);
    wait_step(n);
    check(coils == 4'b0110 && done == 1'b0, "R9 first budget step", coils, 4'h6);
    wait_step(n);
    check(coils == 4'b0011 && done == 1'b0, "R9 second budget step", coils, 4'h3);
    wait_step(n);
    check(coils == 4'b1001, "R9 third budget step", coils, 4'h9);
    check(done == 1'b1, "R9 done with last step", done, 1);
    quiet = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (step_pulse || coils != 4'b1001) quiet = 0;
    end
    check(quiet, "R9 pattern held after budget", quiet, 1);
    step_count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R10 zero budget keeps done", done, 1);
    quiet = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (step_pulse || coils != 4'b1001) quiet = 0;
    end
    check(quiet, "R10 no step with zero budget", quiet, 1);
    free_run = 1'b1;
    #0.1;
    check(done == 1'b0, "R11 done low in free run", done, 0);
    wait_step(n);
    check(coils == 4'b1100, "R11 free run steps past budget", coils, 4'hc);
    wait_step(n);
    check(coils == 4'b0110, "R11 free run keeps stepping", coils, 4'h6);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_walk(1'b1, 1'b0, 5, 9, "R3 half cw sequence");
    t_walk(1'b0, 1'b0, 6, 5, "R4 full cw sequence");
    t_walk(1'b1, 1'b1, 5, 9, "R5 half ccw sequence");
    t_walk(1'b0, 1'b1, 4, 5, "R5 full ccw sequence");
    t_min_dwell();
    t_mode_switch();
    t_disable_hold();
    t_counted();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule